// File: doc/BRIEF.md
# Write Store Buffer Drain Controller

This block is a small write-coalescing buffer between the slave port of a cache and the downstream memory port. It has three slots. Each slot holds one line of `LINE_BYTES` bytes (32 by default, so 256 bits), the line address and one enable bit per byte. A buffered write that targets a line already held in a slot merges into that slot. A write to any other line takes the lowest free slot. Addresses on both ports are line addresses: the byte offset within the line is carried only by the byte enables.

Each slot leaves the buffer when one of several independent conditions marks it for draining:
- a device-memory write,
- a completely written line,
- 256 cycles of residence,
- least-recently-written selection once all three slots are occupied,
- a read that hits the slot,
- strongly ordered, locked or configuration-space traffic, which drains every slot.

Only one slot is presented to memory at a time. When several slots are marked, the chosen slot is the one with the most urgent reason. A sync command raises a busy status bit that stays set until every slot is empty.

Top module: `wsb_drain_ctrl`

## Requirements
- R1: After reset, `mem_valid` and `sync_busy` are 0 and a write request sees `req_ready` = 1.
- R2: An accepted write with `req_dev` = 1 marks its slot at once, and that slot reaches memory within a few cycles without any other trigger.
- R3: A slot whose byte enables are all 1 is drained. A partially written slot is not drained by this rule.
- R4: A write to a line address already held in a slot merges into that slot. The one resulting drain carries the OR of the byte enables and, for each byte, the most recently written value.
- R5: A partially written slot that no other rule touches drains once it has held data for `AGE_LIMIT` (256) cycles, and not before 200 cycles.
- R6: When all three slots hold data and none is marked, the slot written least recently is drained first. A merge counts as a write.
- R7: An accepted request (read or write) with `req_so`, `req_lock` or `req_cfg` set marks every occupied slot for draining.
- R8: A read (`req_write` = 0) whose line address matches a held slot drains that slot. A read matching no slot drains nothing.
- R9: Drains go out one at a time, and `mem_valid` with its address and enables stays stable until `mem_ready`. Marked slots drain in this order of reason: read hazard, then ordering (strongly ordered, locked, config, device, sync), then full line, then age, then least recently written. Equal reasons go to the lower slot index.
- R10: A write that needs a new slot while all three are occupied, or that hits the slot currently offered to memory, is held with `req_ready` = 0 until a drain completes.
- R11: A `sync_start` pulse sets `sync_busy` in the next cycle. `sync_busy` stays set until every slot is empty. While `sync_busy` is set, writes are held off and every occupied slot is marked for draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Slave-side request present |
| req_write | input | 1 | 1 = buffered write, 0 = read |
| req_addr | input | ADDR_W | Line address of the request |
| req_data | input | 8*LINE_BYTES | Write data for the whole line |
| req_be | input | LINE_BYTES | Byte enables of the write |
| req_dev | input | 1 | Target is device memory |
| req_so | input | 1 | Strongly ordered access |
| req_lock | input | 1 | Locked access |
| req_cfg | input | 1 | Access to configuration register space |
| req_ready | output | 1 | Request accepted this cycle (always 1 for reads) |
| mem_valid | output | 1 | A slot is offered to memory |
| mem_addr | output | ADDR_W | Line address of the offered slot |
| mem_data | output | 8*LINE_BYTES | Line data of the offered slot |
| mem_be | output | LINE_BYTES | Byte enables of the offered slot |
| mem_ready | input | 1 | Memory takes the offered slot |
| sync_start | input | 1 | One-cycle sync command |
| sync_busy | output | 1 | Sync status bit 0: set while a sync is in progress |

## Verification
The assertions assume the following about the inputs:
- A request stays unchanged while `req_valid` is high and `req_ready` is low.
- Only one request is presented per cycle.
- `sync_start` is a single-cycle pulse.

The bench changes request and `mem_ready` inputs only just after a rising edge, and holds each request until it sees `req_ready` at the falling edge. It drops `mem_ready` only to build up backlog, in the priority, stall and sync scenarios. The drain order and the stall are therefore observed against a stable presented slot.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  // Reasons for draining a slot. A larger code means more urgent.
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_LRU   = 3'd1,
    RSN_AGE   = 3'd2,
    RSN_FULL  = 3'd3,
    RSN_ORDER = 3'd4,
    RSN_HAZ   = 3'd5
  } rsn_e;
endpackage

// File: rtl/wsb_slot.sv
module wsb_slot
  import wsb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BYTES     = 32,
  parameter int unsigned AGE_LIMIT = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 alloc,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [8*BYTES-1:0]   wr_data,
  input  logic [BYTES-1:0]     wr_be,
  input  logic                 flag_set,
  input  rsn_e                 flag_rsn,
  input  logic                 rel_en,
  output logic                 vld,
  output logic [ADDR_W-1:0]    addr,
  output logic [8*BYTES-1:0]   data,
  output logic [BYTES-1:0]     be,
  output logic                 flagged,
  output rsn_e                 rsn,
  output logic                 age_hit,
  output logic                 full
);
  localparam int unsigned AGE_W = $clog2(AGE_LIMIT);

  logic               vld_q, vld_d, flg_q, flg_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [8*BYTES-1:0] data_q, data_d;
  logic [BYTES-1:0]   be_q, be_d;
  logic [AGE_W-1:0]   age_q, age_d;
  rsn_e               rsn_q, rsn_d;

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    data_d = data_q;
    be_d   = be_q;
    flg_d  = flg_q;
    rsn_d  = rsn_q;
    age_d  = age_q;
    // Residence counter runs only while the slot holds data that is not yet marked.
    if (vld_q && !flg_q && age_q != AGE_W'(AGE_LIMIT - 1)) age_d = age_q + 1'b1;
    if (rel_en) begin
      vld_d = 1'b0;
      flg_d = 1'b0;
      rsn_d = RSN_NONE;
      be_d  = '0;
      age_d = '0;
    end else begin
      if (wr_en) begin
        for (int b = 0; b < BYTES; b++)
          if (wr_be[b]) data_d[8*b +: 8] = wr_data[8*b +: 8];
        if (alloc) begin
          vld_d  = 1'b1;
          addr_d = wr_addr;
          be_d   = wr_be;
          flg_d  = 1'b0;
          rsn_d  = RSN_NONE;
          age_d  = '0;
        end else begin
          be_d = be_q | wr_be;
          if (!flg_q) age_d = '0;
        end
      end
      if (flag_set) begin
        flg_d = 1'b1;
        if (flag_rsn > rsn_d) rsn_d = flag_rsn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      flg_q  <= 1'b0;
      rsn_q  <= RSN_NONE;
      be_q   <= '0;
      age_q  <= '0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      flg_q  <= flg_d;
      rsn_q  <= rsn_d;
      be_q   <= be_d;
      age_q  <= age_d;
      addr_q <= addr_d;
    end
  end

  // Line data carries no reset; it is qualified by the byte enables.
  always_ff @(posedge clk) begin
    if (wr_en) data_q <= data_d;
  end

  assign vld     = vld_q;
  assign addr    = addr_q;
  assign data    = data_q;
  assign be      = be_q;
  assign flagged = flg_q;
  assign rsn     = rsn_q;
  assign age_hit = vld_q && !flg_q && (age_q == AGE_W'(AGE_LIMIT - 1));
  assign full    = vld_q && (&be_q);
endmodule

// File: rtl/wsb_lru.sv
module wsb_lru #(
  parameter int unsigned N = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [N-1:0]         lru_vec
);
  localparam int unsigned RW = $clog2(N);

  // rank 0 = most recently written, N-1 = least recently written.
  logic [RW-1:0] rank_q [N];
  logic [RW-1:0] rank_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank_d[i] = rank_q[i];
      if (touch) begin
        if (RW'(i) == touch_idx)                 rank_d[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx])  rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= RW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) rank_q[i] <= rank_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lru
    assign lru_vec[g] = (rank_q[g] == RW'(N - 1));
  end
endmodule

// File: rtl/wsb_pick.sv
module wsb_pick
  import wsb_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0]         flg,
  input  rsn_e                 rsn [N],
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  rsn_e best;

  // Strictly greater wins, so on equal reasons the lower index stays selected.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = RSN_NONE;
    for (int i = 0; i < N; i++) begin
      if (flg[i] && (!any || rsn[i] > best)) begin
        any  = 1'b1;
        idx  = ($clog2(N))'(i);
        best = rsn[i];
      end
    end
  end
endmodule

// File: rtl/wsb_drain_ctrl.sv
module wsb_drain_ctrl
  import wsb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned SLOTS      = 3,
  parameter int unsigned AGE_LIMIT  = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [8*LINE_BYTES-1:0] req_data,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic                    req_dev,
  input  logic                    req_so,
  input  logic                    req_lock,
  input  logic                    req_cfg,
  output logic                    req_ready,
  output logic                    mem_valid,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*LINE_BYTES-1:0] mem_data,
  output logic [LINE_BYTES-1:0]   mem_be,
  input  logic                    mem_ready,
  input  logic                    sync_start,
  output logic                    sync_busy
);
  localparam int unsigned IDX_W  = $clog2(SLOTS);
  localparam int unsigned DATA_W = 8 * LINE_BYTES;

  logic [SLOTS-1:0]      slot_vld, slot_flg, slot_age, slot_full, lru_vec, hit_vec;
  logic [ADDR_W-1:0]     slot_addr [SLOTS];
  logic [DATA_W-1:0]     slot_data [SLOTS];
  logic [LINE_BYTES-1:0] slot_be   [SLOTS];
  rsn_e                  slot_rsn  [SLOTS];

  logic             hit, free_ok, wr_room, wr_acc, rd_acc, ord_evt;
  logic [IDX_W-1:0] hit_idx, free_idx, tgt_idx, pick_idx;
  logic             pick_any;
  logic             act_q, act_d, sync_q, sync_d;
  logic [IDX_W-1:0] act_idx_q, act_idx_d;

  // Request lookup: line match and lowest free slot.
  always_comb begin
    hit = 1'b0; hit_idx = '0; free_ok = 1'b0; free_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      hit_vec[i] = slot_vld[i] && (slot_addr[i] == req_addr);
      if (hit_vec[i] && !hit) begin hit = 1'b1; hit_idx = IDX_W'(i); end
      if (!slot_vld[i] && !free_ok) begin free_ok = 1'b1; free_idx = IDX_W'(i); end
    end
  end

  assign wr_room   = hit ? !(act_q && act_idx_q == hit_idx) : free_ok;
  assign req_ready = !req_write || (!sync_q && wr_room);
  assign wr_acc    = req_valid && req_write && req_ready;
  assign rd_acc    = req_valid && !req_write;
  assign ord_evt   = req_valid && req_ready && (req_so || req_lock || req_cfg);
  assign tgt_idx   = hit ? hit_idx : free_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic tgt_g, held_g, rel_g, fs_g;
    rsn_e fr_g;
    assign tgt_g  = wr_acc && (tgt_idx == IDX_W'(g));
    assign held_g = slot_vld[g] || tgt_g;
    assign rel_g  = act_q && mem_ready && (act_idx_q == IDX_W'(g));

    // Drain trigger evaluation, most urgent reason first.
    always_comb begin
      fs_g = 1'b1;
      fr_g = RSN_NONE;
      if (rd_acc && hit_vec[g])                                  fr_g = RSN_HAZ;
      else if (held_g && (ord_evt || sync_q || (tgt_g && req_dev))) fr_g = RSN_ORDER;
      else if (slot_full[g] && !slot_flg[g])                     fr_g = RSN_FULL;
      else if (slot_age[g])                                      fr_g = RSN_AGE;
      else if ((&slot_vld) && !(|slot_flg) && lru_vec[g])        fr_g = RSN_LRU;
      else                                                       fs_g = 1'b0;
    end

    wsb_slot #(.ADDR_W(ADDR_W), .BYTES(LINE_BYTES), .AGE_LIMIT(AGE_LIMIT)) i_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tgt_g), .alloc(!hit), .wr_addr(req_addr), .wr_data(req_data), .wr_be(req_be),
      .flag_set(fs_g), .flag_rsn(fr_g), .rel_en(rel_g),
      .vld(slot_vld[g]), .addr(slot_addr[g]), .data(slot_data[g]), .be(slot_be[g]),
      .flagged(slot_flg[g]), .rsn(slot_rsn[g]), .age_hit(slot_age[g]), .full(slot_full[g])
    );
  end

  wsb_lru #(.N(SLOTS)) i_lru (
    .clk(clk), .rst_n(rst_n), .touch(wr_acc), .touch_idx(tgt_idx), .lru_vec(lru_vec)
  );

  wsb_pick #(.N(SLOTS)) i_pick (
    .flg(slot_flg), .rsn(slot_rsn), .any(pick_any), .idx(pick_idx)
  );

  // One slot at a time is offered downstream; the choice is held until taken.
  always_comb begin
    act_d     = act_q;
    act_idx_d = act_idx_q;
    if (act_q) begin
      if (mem_ready) act_d = 1'b0;
    end else if (pick_any) begin
      act_d     = 1'b1;
      act_idx_d = pick_idx;
    end
    sync_d = sync_start || (sync_q && (|slot_vld));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      act_idx_q <= '0;
      sync_q    <= 1'b0;
    end else begin
      act_q     <= act_d;
      act_idx_q <= act_idx_d;
      sync_q    <= sync_d;
    end
  end

  assign mem_valid = act_q;
  assign mem_addr  = slot_addr[act_idx_q];
  assign mem_data  = slot_data[act_idx_q];
  assign mem_be    = slot_be[act_idx_q];
  assign sync_busy = sync_q;
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned SLOTS      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic                  req_ready,
  input logic                  req_dev,
  input logic                  mem_valid,
  input logic                  mem_ready,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [LINE_BYTES-1:0] mem_be,
  input logic                  sync_busy,
  input logic [SLOTS-1:0]      slot_vld,
  input logic [SLOTS-1:0]      slot_flg
);
  // R9: an offered slot is held with stable address and enables until taken.
  a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be));

  // R9: nothing is offered downstream unless a slot holds data.
  a_r9_offer_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (|slot_vld));

  // R2: a device write leaves a marked slot behind it.
  a_r2_device_marks: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_ready && req_dev |=> (|slot_flg));

  // R6: a full buffer with no marked slot gets one marked in the next cycle.
  a_r6_lru_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_vld) && !(|slot_flg) |=> (|slot_flg));

  // R11: busy persists while any slot still holds data.
  a_r11_busy_until_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy && (|slot_vld) |=> sync_busy);

  // R11: no write is taken during a sync.
  a_r11_no_write_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |-> !(req_valid && req_write && req_ready));
endmodule

bind wsb_drain_ctrl wsb_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS)
) i_wsb_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .req_dev(req_dev), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_be(mem_be), .sync_busy(sync_busy),
  .slot_vld(slot_vld), .slot_flg(slot_flg)
);

// File: tb/test_wsb_drain_ctrl.sv
module test_wsb_drain_ctrl;
  localparam int AW = 20;
  localparam int NB = 32;

  logic clk, rst_n;
  logic req_valid, req_write, req_dev, req_so, req_lock, req_cfg, req_ready;
  logic [AW-1:0] req_addr;
  logic [8*NB-1:0] req_data;
  logic [NB-1:0] req_be;
  logic mem_valid, mem_ready, sync_start, sync_busy, stall_mem;
  logic [AW-1:0] mem_addr;
  logic [8*NB-1:0] mem_data;
  logic [NB-1:0] mem_be;

  int n_chk, n_err, log_n;
  logic [AW-1:0]   log_addr [0:63];
  logic [NB-1:0]   log_be   [0:63];
  logic [8*NB-1:0] log_data [0:63];

  assign mem_ready = !stall_mem;

  wsb_drain_ctrl i_wsb_drain_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .req_dev(req_dev),
    .req_so(req_so), .req_lock(req_lock), .req_cfg(req_cfg), .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .mem_ready(mem_ready), .sync_start(sync_start), .sync_busy(sync_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Record every completed drain at the falling edge.
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (log_n < 64) begin
        log_addr[log_n] = mem_addr;
        log_be[log_n]   = mem_be;
        log_data[log_n] = mem_data;
      end
      log_n++;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [8*NB-1:0] act, input logic [8*NB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  function automatic logic [8*NB-1:0] pat(input logic [AW-1:0] a, input logic [7:0] s);
    return {8{12'(a) ^ 12'hA5C, s, 12'h3E1}};
  endfunction

  // attr bits: [0] device, [1] strongly ordered, [2] locked, [3] config space
  task automatic drive(input bit wr, input logic [AW-1:0] a, input logic [NB-1:0] be,
                       input logic [8*NB-1:0] d, input logic [3:0] attr);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_data = d;
    req_dev = attr[0]; req_so = attr[1]; req_lock = attr[2]; req_cfg = attr[3];
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_write = 1'b0; req_dev = 1'b0; req_so = 1'b0;
    req_lock = 1'b0; req_cfg = 1'b0; req_be = '0;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [NB-1:0] be,
                       input logic [8*NB-1:0] d, input logic [3:0] attr);
    bit acc;
    acc = 1'b0;
    drive(wr, a, be, d, attr);
    while (!acc) begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk); #2;
    end
    idle_req();
  endtask

  task automatic flush();
    sync_start = 1'b1; tick(1); sync_start = 1'b0;
    while (sync_busy) tick(1);
  endtask

  task automatic t_reset();
    req_write = 1'b1; #1;
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", 256'(mem_valid), 256'd0);
    chk(sync_busy == 1'b0, "R1 sync_busy after reset", 256'(sync_busy), 256'd0);
    chk(req_ready == 1'b1, "R1 write ready after reset", 256'(req_ready), 256'd1);
    req_write = 1'b0;
  endtask

  task automatic t_device();
    int b0 = log_n;
    issue(1'b1, 20'h10, 32'h0000_00FF, pat(20'h10, 8'h01), 4'b0001);
    tick(4);
    chk(log_n == b0 + 1, "R2 device write drained", 256'(log_n - b0), 256'd1);
    chk(log_addr[b0] == 20'h10, "R2 device drain address", 256'(log_addr[b0]), 256'h10);
    chk(log_be[b0] == 32'h0000_00FF, "R2 device drain enables", 256'(log_be[b0]), 256'hFF);
  endtask

  task automatic t_full();
    int b0 = log_n;
    issue(1'b1, 20'h20, '1, pat(20'h20, 8'h02), 4'b0000);
    tick(5);
    chk(log_n == b0 + 1, "R3 full line drained", 256'(log_n - b0), 256'd1);
    chk(log_addr[b0] == 20'h20, "R3 full line address", 256'(log_addr[b0]), 256'h20);
  endtask

  task automatic t_merge();
    int b0 = log_n;
    logic [8*NB-1:0] d1, d2, exp;
    d1 = pat(20'h30, 8'h11); d2 = pat(20'h30, 8'h22);
    exp = {d2[255:128], d1[127:0]};
    issue(1'b1, 20'h30, 32'h0000_FFFF, d1, 4'b0000);
    tick(3);
    chk(log_n == b0, "R3 partial line not drained", 256'(log_n - b0), 256'd0);
    issue(1'b1, 20'h30, 32'hFFFF_0000, d2, 4'b0000);
    tick(6);
    chk(log_n == b0 + 1, "R4 merged line single drain", 256'(log_n - b0), 256'd1);
    chk(log_be[b0] == '1, "R4 merged enables", 256'(log_be[b0]), 256'hFFFF_FFFF);
    chk(log_data[b0] == exp, "R4 merged data", log_data[b0], exp);
  endtask

  task automatic t_hazard();
    int b0 = log_n;
    issue(1'b1, 20'h40, 32'h0000_000F, pat(20'h40, 8'h04), 4'b0000);
    issue(1'b0, 20'h41, '0, '0, 4'b0000);
    tick(6);
    chk(log_n == b0, "R8 non-matching read drains nothing", 256'(log_n - b0), 256'd0);
    issue(1'b0, 20'h40, '0, '0, 4'b0000);
    tick(5);
    chk(log_n == b0 + 1, "R8 matching read drains slot", 256'(log_n - b0), 256'd1);
    chk(log_addr[b0] == 20'h40, "R8 hazard drain address", 256'(log_addr[b0]), 256'h40);
  endtask

  task automatic t_age();
    int b0 = log_n;
    issue(1'b1, 20'h50, 32'h0000_0F00, pat(20'h50, 8'h05), 4'b0000);
    tick(200);
    chk(log_n == b0, "R5 no drain before 200 cycles", 256'(log_n - b0), 256'd0);
    tick(70);
    chk(log_n == b0 + 1, "R5 drained after age limit", 256'(log_n - b0), 256'd1);
    chk(log_addr[b0] == 20'h50, "R5 aged drain address", 256'(log_addr[b0]), 256'h50);
  endtask

  task automatic t_lru();
    int b0 = log_n;
    issue(1'b1, 20'h60, 32'h1, pat(20'h60, 8'h06), 4'b0000);
    issue(1'b1, 20'h61, 32'h1, pat(20'h61, 8'h06), 4'b0000);
    issue(1'b1, 20'h60, 32'h2, pat(20'h60, 8'h07), 4'b0000);
    issue(1'b1, 20'h62, 32'h1, pat(20'h62, 8'h06), 4'b0000);
    tick(5);
    chk(log_n == b0 + 1, "R6 one slot drained when all held", 256'(log_n - b0), 256'd1);
    chk(log_addr[b0] == 20'h61, "R6 least recently written drained", 256'(log_addr[b0]), 256'h61);
    flush();
  endtask

  task automatic t_stall();
    int b0 = log_n;
    bit acc;
    stall_mem = 1'b1;
    issue(1'b1, 20'h70, 32'h1, pat(20'h70, 8'h08), 4'b0000);
    issue(1'b1, 20'h71, 32'h1, pat(20'h71, 8'h08), 4'b0000);
    issue(1'b1, 20'h72, 32'h1, pat(20'h72, 8'h08), 4'b0000);
    tick(3);
    drive(1'b1, 20'h73, 32'h1, pat(20'h73, 8'h08), 4'b0000);
    tick(2);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 write held while all slots busy", 256'(req_ready), 256'd0);
    chk(mem_valid && mem_addr == 20'h70, "R9 offered slot held under backpressure",
        256'(mem_addr), 256'h70);
    @(posedge clk); #2;
    stall_mem = 1'b0;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = req_ready; @(posedge clk); #2;
    end
    idle_req();
    chk(log_addr[b0] == 20'h70, "R10 stalled write waited for drain", 256'(log_addr[b0]), 256'h70);
    flush();
    chk(log_n == b0 + 4, "R10 all four lines reached memory", 256'(log_n - b0), 256'd4);
  endtask

  task automatic t_prio();
    int b0 = log_n;
    stall_mem = 1'b1;
    issue(1'b1, 20'h80, 32'h1, pat(20'h80, 8'h09), 4'b0001);
    issue(1'b1, 20'h81, '1, pat(20'h81, 8'h09), 4'b0000);
    issue(1'b1, 20'h82, 32'h1, pat(20'h82, 8'h09), 4'b0000);
    issue(1'b0, 20'h82, '0, '0, 4'b0000);
    tick(2);
    stall_mem = 1'b0;
    tick(10);
    chk(log_n == b0 + 3, "R9 three drains", 256'(log_n - b0), 256'd3);
    chk(log_addr[b0] == 20'h80, "R9 in-flight slot first", 256'(log_addr[b0]), 256'h80);
    chk(log_addr[b0+1] == 20'h82, "R9 hazard before full", 256'(log_addr[b0+1]), 256'h82);
    chk(log_addr[b0+2] == 20'h81, "R9 full line last", 256'(log_addr[b0+2]), 256'h81);
  endtask

  task automatic t_order();
    for (int k = 0; k < 3; k++) begin
      int b0 = log_n;
      issue(1'b1, 20'h90, 32'h1, pat(20'h90, 8'h0A), 4'b0000);
      issue(1'b1, 20'h91, 32'h1, pat(20'h91, 8'h0A), 4'b0000);
      issue(1'b0, 20'h300, '0, '0, 4'(4'b0010 << k));
      tick(6);
      chk(log_n == b0 + 2, "R7 ordering access drains all slots", 256'(log_n - b0), 256'd2);
      chk(log_addr[b0] == 20'h90 && log_addr[b0+1] == 20'h91, "R7 R9 equal reasons by index",
          256'(log_addr[b0]), 256'h90);
    end
  endtask

  task automatic t_sync();
    int b0 = log_n;
    issue(1'b1, 20'hA0, 32'h1, pat(20'hA0, 8'h0B), 4'b0000);
    issue(1'b1, 20'hA1, 32'h1, pat(20'hA1, 8'h0B), 4'b0000);
    stall_mem = 1'b1;
    sync_start = 1'b1; tick(1); sync_start = 1'b0;
    chk(sync_busy == 1'b1, "R11 busy set after sync", 256'(sync_busy), 256'd1);
    tick(20);
    chk(sync_busy == 1'b1, "R11 busy held while slots occupied", 256'(sync_busy), 256'd1);
    drive(1'b1, 20'hA2, 32'h1, pat(20'hA2, 8'h0B), 4'b0000);
    @(negedge clk);
    chk(req_ready == 1'b0, "R11 write held off during sync", 256'(req_ready), 256'd0);
    @(posedge clk); #2;
    idle_req();
    stall_mem = 1'b0;
    tick(10);
    chk(sync_busy == 1'b0, "R11 busy clear once empty", 256'(sync_busy), 256'd0);
    chk(log_n == b0 + 2, "R11 sync drained every slot", 256'(log_n - b0), 256'd2);
  endtask

  initial begin
    n_chk = 0; n_err = 0; log_n = 0;
    rst_n = 1'b0; stall_mem = 1'b0; sync_start = 1'b0;
    req_addr = '0; req_data = '0;
    idle_req();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick(1);
    t_reset();
    t_device();
    t_full();
    t_merge();
    t_hazard();
    t_age();
    t_lru();
    t_stall();
    t_prio();
    t_order();
    t_sync();
    report();
    $finish;
  end
endmodule